// File: doc/BRIEF.md
# Slot Configuration Register Access Unit

This unit sits between a host byte bus and a set of adapter slots, each of which holds a small bank of byte-wide configuration registers. Software reaches a slot's bank in three steps. It first parks a board-level setup register in its released state. It then writes a slot number, with an enable bit set, into an adapter setup register. After that, a window of consecutive host ports maps one-to-one onto the registers of the chosen slot. Clearing the adapter setup register closes the window again.

When the host bus is idle, the unit borrows the slot-side interface to poll the error register of each slot in turn. Each slot carries an active-low check flag and a second active-low flag that marks extended error status as valid. The unit records every failing slot in a mask and raises a level error request. It also reports the one-based number of the lowest failing slot, so a handler can find the culprit without scanning.

Top module: `slot_cfg_unit`

## Requirements
- R1: After reset no slot is selected, both masks are zero, `err_irq` is low, `err_first` is 0, the board setup register reads 0xFF and the adapter setup register reads 0x00.
- R2: Any value other than 0xFF written to the board setup port (default 0x94) blocks slot access: window reads return 0xFF and window writes are dropped. Writing 0xFF restores access.
- R3: Writing the adapter setup port (default 0x96) selects the slot given by bits 2:0 when bit 3 is 1. Bits 7:4 have no effect. A value with bit 3 clear, including 0, deselects every slot.
- R4: With a slot selected, a host read of port WIN_BASE+n (default base 0x40, n = 0..7) returns register n of that slot, in the same cycle.
- R5: With a slot selected, a host write of port WIN_BASE+n stores the byte in register n of that slot only.
- R6: With no slot selected, window reads return 0xFF and window writes reach no slot.
- R7: On every cycle with neither `host_rd` nor `host_wr` asserted, the scanner reads register 5 of one slot. Slots are visited in ascending order, starting at 0 after reset and wrapping. Bit `chk_mask[s]` is set when bit 7 of that register is 0 and cleared when it is 1. The update is visible after the clock edge.
- R8: In the same visit, `stat_mask[s]` is set exactly when bits 7 and 6 of register 5 are both 0.
- R9: `err_irq` is high exactly while any bit of `chk_mask` is set.
- R10: During any host access, to any port, the scanner neither advances nor changes either mask.
- R11: Host reads of the two setup ports return the last value written to them.
- R12: `err_first` is 0 when `chk_mask` is empty. Otherwise it is the one-based number of the lowest-numbered failing slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host port address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte (combinational) |
| slot_sel | output | NSLOTS | One-hot slot select |
| slot_idx | output | log2(NREGS) | Register index within the slot |
| slot_wr | output | 1 | Slot register write strobe |
| slot_wdata | output | DATA_W | Slot write byte |
| slot_rdata | input | DATA_W | Read byte from the selected slot |
| chk_mask | output | NSLOTS | Slots with the check flag active |
| stat_mask | output | NSLOTS | Slots with extended status valid |
| err_irq | output | 1 | Level error request |
| err_first | output | log2(NSLOTS+1) | One-based lowest failing slot, 0 if none |

## Verification
The bench builds the unit with its default parameters: eight slots of eight registers, the enable at bit 3, and the check and status flags at bits 7 and 6 of register 5. With these values every slot number can be selected, and the scanner pointer wraps many times within a short run. A host burst of more than eight cycles then proves that the scan stalls instead of merely slowing down. Two failing slots with different flag combinations cover both masks, the lowest-slot report and the clearing of a fault.

// File: rtl/scu_pkg.sv
package scu_pkg;
   typedef enum logic [1:0] {
      PK_NONE,
      PK_BOARD,
      PK_ADAPT,
      PK_WIN
   } port_kind_e;
endpackage

// File: rtl/scu_decode.sv
module scu_decode
   import scu_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] BRD_PORT = 'h94,
   parameter logic [ADDR_W-1:0] ADP_PORT = 'h96,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h40,
   parameter int                NREGS    = 8,
   localparam int               IDX_W    = $clog2(NREGS)
) (
   input  logic [ADDR_W-1:0] addr,
   output port_kind_e        kind,
   output logic [IDX_W-1:0]  idx
);
   logic [ADDR_W-1:0] off;

   assign off = addr - WIN_BASE;
   assign idx = off[IDX_W-1:0];

   always_comb begin
      if (addr == BRD_PORT)
         kind = PK_BOARD;
      else if (addr == ADP_PORT)
         kind = PK_ADAPT;
      else if ((addr >= WIN_BASE) && (off < ADDR_W'(NREGS)))
         kind = PK_WIN;
      else
         kind = PK_NONE;
   end
endmodule

// File: rtl/scu_setup.sv
module scu_setup #(
   parameter int DATA_W  = 8,
   parameter int SLOT_W  = 3,
   parameter int ENA_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_board,
   input  logic              wr_adapt,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] board_q,
   output logic [DATA_W-1:0] adapt_q,
   output logic              sel_valid,
   output logic [SLOT_W-1:0] sel_slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         board_q <= '1;
         adapt_q <= '0;
      end else begin
         if (wr_board) board_q <= wdata;
         if (wr_adapt) adapt_q <= wdata;
      end
   end

   // access needs the board register released (all ones) and the enable bit
   assign sel_valid = (&board_q) && adapt_q[ENA_BIT];
   assign sel_slot  = adapt_q[SLOT_W-1:0];
endmodule

// File: rtl/scu_scan.sv
module scu_scan #(
   parameter int NSLOTS = 8,
   localparam int SLOT_W = $clog2(NSLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_en,
   input  logic              chk_n,
   input  logic              stat_n,
   output logic [SLOT_W-1:0] ptr,
   output logic [NSLOTS-1:0] chk_mask,
   output logic [NSLOTS-1:0] stat_mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (scan_en) ptr <= ptr + 1'b1;
   end

   for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      logic chk_q, stat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chk_q  <= 1'b0;
            stat_q <= 1'b0;
         end else if (scan_en && (ptr == SLOT_W'(s))) begin
            chk_q  <= ~chk_n;
            stat_q <= ~chk_n & ~stat_n;
         end
      end
      assign chk_mask[s]  = chk_q;
      assign stat_mask[s] = stat_q;
   end
endmodule

// File: rtl/slot_cfg_unit.sv
module slot_cfg_unit
   import scu_pkg::*;
#(
   parameter int                NSLOTS   = 8,
   parameter int                NREGS    = 8,
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] BRD_PORT = 'h94,
   parameter logic [ADDR_W-1:0] ADP_PORT = 'h96,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h40,
   parameter int                ENA_BIT  = 3,
   parameter int                CHK_REG  = 5,
   parameter int                CHK_BIT  = 7,
   parameter int                STAT_BIT = 6,
   localparam int               SLOT_W   = $clog2(NSLOTS),
   localparam int               IDX_W    = $clog2(NREGS),
   localparam int               FIRST_W  = $clog2(NSLOTS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic               host_rd,
   input  logic               host_wr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [NSLOTS-1:0]  slot_sel,
   output logic [IDX_W-1:0]   slot_idx,
   output logic               slot_wr,
   output logic [DATA_W-1:0]  slot_wdata,
   input  logic [DATA_W-1:0]  slot_rdata,
   output logic [NSLOTS-1:0]  chk_mask,
   output logic [NSLOTS-1:0]  stat_mask,
   output logic               err_irq,
   output logic [FIRST_W-1:0] err_first
);
   localparam logic [IDX_W-1:0] CHK_IDX = IDX_W'(CHK_REG);

   if (NSLOTS < 2 || (1 << SLOT_W) != NSLOTS) begin : g_bad_nslots
      $error("NSLOTS must be a power of two of at least 2");
   end
   if (NREGS < 2 || (1 << IDX_W) != NREGS || IDX_W > ADDR_W) begin : g_bad_nregs
      $error("NREGS must be a power of two that fits the address");
   end
   if (ENA_BIT < SLOT_W || ENA_BIT >= DATA_W) begin : g_bad_ena
      $error("enable bit must lie above the slot field inside the byte");
   end
   if (CHK_BIT == STAT_BIT || CHK_BIT >= DATA_W || STAT_BIT >= DATA_W) begin : g_bad_flags
      $error("check and status flags need distinct in-range bits");
   end
   if (CHK_REG >= NREGS) begin : g_bad_chkreg
      $error("check register outside the window");
   end

   port_kind_e        kind;
   logic [IDX_W-1:0]  win_idx;
   logic [DATA_W-1:0] board_q, adapt_q;
   logic              sel_valid;
   logic [SLOT_W-1:0] sel_slot, scan_ptr;
   logic              host_busy, win_hit, win_acc;

   scu_decode #(
      .ADDR_W(ADDR_W), .BRD_PORT(BRD_PORT), .ADP_PORT(ADP_PORT),
      .WIN_BASE(WIN_BASE), .NREGS(NREGS)
   ) u_dec (
      .addr(host_addr), .kind(kind), .idx(win_idx)
   );

   assign host_busy = host_rd | host_wr;
   assign win_hit   = (kind == PK_WIN);
   assign win_acc   = host_busy && win_hit && sel_valid;

   scu_setup #(
      .DATA_W(DATA_W), .SLOT_W(SLOT_W), .ENA_BIT(ENA_BIT)
   ) u_setup (
      .clk(clk), .rst_n(rst_n),
      .wr_board(host_wr && kind == PK_BOARD),
      .wr_adapt(host_wr && kind == PK_ADAPT),
      .wdata(host_wdata),
      .board_q(board_q), .adapt_q(adapt_q),
      .sel_valid(sel_valid), .sel_slot(sel_slot)
   );

   scu_scan #(.NSLOTS(NSLOTS)) u_scan (
      .clk(clk), .rst_n(rst_n),
      .scan_en(!host_busy),
      .chk_n(slot_rdata[CHK_BIT]), .stat_n(slot_rdata[STAT_BIT]),
      .ptr(scan_ptr), .chk_mask(chk_mask), .stat_mask(stat_mask)
   );

   // host window access owns the slot side; an idle bus lends it to the scanner
   always_comb begin
      slot_sel = '0;
      slot_idx = '0;
      slot_wr  = 1'b0;
      if (win_acc) begin
         slot_sel[sel_slot] = 1'b1;
         slot_idx           = win_idx;
         slot_wr            = host_wr;
      end else if (!host_busy) begin
         slot_sel[scan_ptr] = 1'b1;
         slot_idx           = CHK_IDX;
      end
   end
   assign slot_wdata = host_wdata;

   always_comb begin
      unique case (kind)
         PK_BOARD: host_rdata = board_q;
         PK_ADAPT: host_rdata = adapt_q;
         PK_WIN:   host_rdata = sel_valid ? slot_rdata : '1;
         default:  host_rdata = '1;
      endcase
   end

   assign err_irq = |chk_mask;

   always_comb begin
      err_first = '0;
      for (int i = NSLOTS - 1; i >= 0; i--)
         if (chk_mask[i]) err_first = FIRST_W'(i + 1);
   end
endmodule

// File: rtl/slot_cfg_unit_chk.sv
module slot_cfg_unit_chk #(
   parameter int NSLOTS  = 8,
   parameter int DATA_W  = 8,
   parameter int FIRST_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_busy,
   input logic               host_rd,
   input logic               win_hit,
   input logic [DATA_W-1:0]  host_rdata,
   input logic [NSLOTS-1:0]  slot_sel,
   input logic               slot_wr,
   input logic [NSLOTS-1:0]  chk_mask,
   input logic [NSLOTS-1:0]  stat_mask,
   input logic [FIRST_W-1:0] err_first
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_sel)); // R3
   AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr |-> (slot_sel != '0)); // R5
   AST_CLOSED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && win_hit && slot_sel == '0) |-> (host_rdata == '1)); // R6
   AST_ONE_SLOT_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chk_mask ^ $past(chk_mask)) <= 1); // R7
   AST_STAT_WITHIN_CHK: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_mask & ~chk_mask) == '0); // R8
   AST_SCAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy |=> ($stable(chk_mask) && $stable(stat_mask))); // R10
   AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_mask == '0) == (err_first == '0)); // R12
endmodule

bind slot_cfg_unit slot_cfg_unit_chk #(
   .NSLOTS(NSLOTS), .DATA_W(DATA_W), .FIRST_W(FIRST_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .host_rd(host_rd),
   .win_hit(win_hit), .host_rdata(host_rdata), .slot_sel(slot_sel),
   .slot_wr(slot_wr), .chk_mask(chk_mask), .stat_mask(stat_mask),
   .err_first(err_first)
);

// File: tb/tb_slot_cfg_unit.sv
`timescale 1ns/1ps
module tb_slot_cfg_unit;
   localparam logic [7:0] BRD = 8'h94, ADP = 8'h96, WIN = 8'h40;

   logic       clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n;
   logic [7:0] host_addr, host_wdata, slot_rdata;
   logic       host_rd, host_wr;
   logic [7:0] host_rdata, slot_wdata, slot_sel, chk_mask, stat_mask;
   logic [2:0] slot_idx;
   logic       slot_wr, err_irq;
   logic [3:0] err_first;

   slot_cfg_unit dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .slot_sel(slot_sel), .slot_idx(slot_idx), .slot_wr(slot_wr),
      .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .chk_mask(chk_mask),
      .stat_mask(stat_mask), .err_irq(err_irq), .err_first(err_first)
   );

   // slot-side environment: eight banks of eight registers
   logic [7:0] env_mem [8][8];
   always_comb begin
      slot_rdata = 8'h00;
      for (int s = 0; s < 8; s++)
         if (slot_sel[s]) slot_rdata = env_mem[s][slot_idx];
   end

   // behavioural reference state
   logic [7:0] m_mem [8][8];
   logic [7:0] m_brd, m_adp, m_chk, m_stat;
   int         m_ptr;
   int         n_cmp = 0, n_bad = 0;

   function automatic bit m_open();
      return (m_brd == 8'hFF) && m_adp[3];
   endfunction

   function automatic bit in_win(logic [7:0] a);
      return (a >= WIN) && (a < WIN + 8);
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      if (a == BRD) return m_brd;
      if (a == ADP) return m_adp;
      if (in_win(a)) return m_open() ? m_mem[m_adp[2:0]][a - WIN] : 8'hFF;
      return 8'hFF;
   endfunction

   function automatic logic [7:0] exp_first();
      for (int s = 0; s < 8; s++) if (m_chk[s]) return 8'(s + 1);
      return 8'h00;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(logic [7:0] a, bit rd, bit wr, logic [7:0] wd, string req);
      @(negedge clk);
      host_addr = a; host_rd = rd; host_wr = wr; host_wdata = wd;
      #1;
      if (rd) check(req, host_rdata, exp_rd(a));
      check("R7", chk_mask, m_chk);
      check("R8", stat_mask, m_stat);
      check("R9", {7'b0, err_irq}, {7'b0, |m_chk});
      check("R12", {4'b0, err_first}, exp_first());
      // environment takes the slot-side write
      if (slot_wr)
         for (int s = 0; s < 8; s++)
            if (slot_sel[s]) env_mem[s][slot_idx] = slot_wdata;
      // reference update for the coming edge
      if (wr) begin
         if (a == BRD) m_brd = wd;
         else if (a == ADP) m_adp = wd;
         else if (in_win(a) && m_open()) m_mem[m_adp[2:0]][a - WIN] = wd;
      end
      if (!rd && !wr) begin
         m_chk[m_ptr]  = !m_mem[m_ptr][5][7];
         m_stat[m_ptr] = !m_mem[m_ptr][5][7] && !m_mem[m_ptr][5][6];
         m_ptr = (m_ptr + 1) % 8;
      end
   endtask

   task automatic idle(int n, string req);
      for (int i = 0; i < n; i++) step(8'h00, 0, 0, 8'h00, req);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
      $finish;
   end

   initial begin
      for (int s = 0; s < 8; s++)
         for (int r = 0; r < 8; r++) begin
            env_mem[s][r] = (r == 5) ? 8'hFF : 8'((s << 4) | r);
            m_mem[s][r]   = env_mem[s][r];
         end
      m_brd = 8'hFF; m_adp = 8'h00; m_chk = 8'h00; m_stat = 8'h00; m_ptr = 0;
      // hold a host read across reset release so no scan happens before the first step
      rst_n = 1'b0; host_addr = 8'h00; host_rd = 1'b1; host_wr = 1'b0; host_wdata = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(WIN + 8'd1, 1, 0, 0, "R1");
      step(BRD, 1, 0, 0, "R1");
      step(ADP, 1, 0, 0, "R1");

      // R6: closed window
      step(WIN + 8'd2, 0, 1, 8'hAA, "R6");
      step(WIN + 8'd2, 1, 0, 0, "R6");
      step(ADP, 0, 1, 8'h0A, "R3");
      step(WIN + 8'd2, 1, 0, 0, "R6");

      // R4: full window of slot 3
      step(ADP, 0, 1, 8'h0B, "R3");
      for (int n = 0; n < 8; n++) step(WIN + 8'(n), 1, 0, 0, "R4");

      // R5: write reaches only the selected slot
      step(WIN + 8'd2, 0, 1, 8'h5A, "R5");
      step(WIN + 8'd2, 1, 0, 0, "R5");
      step(ADP, 0, 1, 8'h0C, "R5");
      step(WIN + 8'd2, 1, 0, 0, "R5");

      // R3: upper bits ignored, enable required
      step(ADP, 0, 1, 8'hFD, "R3");
      step(WIN + 8'd3, 1, 0, 0, "R3");
      step(ADP, 1, 0, 0, "R11");
      step(ADP, 0, 1, 8'h05, "R3");
      step(WIN + 8'd3, 1, 0, 0, "R3");
      step(ADP, 0, 1, 8'h00, "R3");
      step(WIN + 8'd3, 1, 0, 0, "R3");

      // R2: board setup blocks slot access
      step(ADP, 0, 1, 8'h0B, "R2");
      step(BRD, 0, 1, 8'h00, "R2");
      step(BRD, 1, 0, 0, "R11");
      step(WIN + 8'd1, 1, 0, 0, "R2");
      step(WIN + 8'd1, 0, 1, 8'h11, "R2");
      step(BRD, 0, 1, 8'hFE, "R2");
      step(WIN + 8'd1, 1, 0, 0, "R2");
      step(BRD, 0, 1, 8'hFF, "R2");
      step(WIN + 8'd1, 1, 0, 0, "R2");

      // R7, R8: faults in slot 2 (check only) and slot 6 (check plus status)
      step(ADP, 0, 1, 8'h0A, "R7");
      step(WIN + 8'd5, 0, 1, 8'h7F, "R7");
      step(ADP, 0, 1, 8'h0E, "R8");
      step(WIN + 8'd5, 0, 1, 8'h3F, "R8");
      step(ADP, 0, 1, 8'h00, "R7");
      idle(11, "R7");

      // R10: long host burst freezes the scan
      for (int i = 0; i < 12; i++) step(8'h00, 1, 0, 0, "R10");
      idle(3, "R10");

      // clear the slot 2 fault; R12 moves to slot 6
      step(ADP, 0, 1, 8'h0A, "R7");
      step(WIN + 8'd5, 0, 1, 8'hFF, "R7");
      step(ADP, 0, 1, 8'h00, "R7");
      idle(10, "R12");

      summary();
      $finish;
   end
endmodule